// File: doc/BRIEF.md
# Direction-Selected SPI Slave with Byte FIFOs

This block is an SPI slave, bus mode 0, that connects a serial master to two local byte queues: a receive queue the master fills and a transmit queue the master drains. Every chip-select frame begins with one command byte. Bit 0 of that byte fixes the frame's direction. With bit 0 clear, the frame is a write: each later byte is stored in the receive queue and the slave keeps its data output low. With bit 0 set, the frame is a read: the slave sends transmit-queue bytes and ignores everything else the master sends. The command byte itself is never stored.

The local side is a small register port with three addresses: a control word, a data window that pushes into the transmit queue on write and pops the receive queue on read, and a status word with sticky error flags and queue levels. The serial pins are brought into the system clock domain through a two-stage synchronizer. Each SCLK half-period must therefore last at least four system clocks.

Top module: `spi_dir_slave`

## Requirements
- R1: Within a frame, the first 8 bits received on MOSI (MSB first) form the command byte. Its bit 0 selects the direction: 0 means write, 1 means read. The command byte never enters the receive queue.
- R2: In a write frame, every later complete byte is pushed into the receive queue in arrival order, assembled MSB first, and MISO stays 0 for the whole frame.
- R3: In a read frame, MISO is 0 during the command byte. Each later byte slot carries the next transmit-queue byte, MSB first, with MISO changing after falling SCLK. MOSI data in a read frame leaves the receive queue unchanged.
- R4: Control word at address 0: bit 0 enable, bit 1 SPI select, bit 8 transmit enable, bit 9 receive enable. Frames are serviced only while bits 0 and 1 are both 1. Otherwise (for example a control word of zero) a frame changes neither queue and MISO stays 0.
- R5: Control bit 7 (break) has no effect on any frame or queue.
- R6: While control bit 8 is 0, the transmit queue is held empty and writes to address 1 are dropped. Clearing and then setting bit 8 therefore empties the transmit queue.
- R7: While control bit 9 is 0, bytes of a write frame are discarded.
- R8: Raising the active-low chip select ends the frame, discards any partial byte and rearms command-byte detection for the next frame.
- R9: Both queues hold 16 bytes. A byte arriving while the receive queue is full is lost and sets sticky overrun (status bit 0). A read slot that starts while the transmit queue is empty sends 0x00 and sets sticky underrun (status bit 1). A status write clears each flag whose written bit is 0, so writing zero clears both.
- R10: Address 1 read returns the receive-queue head in bits 7:0 and pops it, or returns 0 when the queue is empty. Address 2 read returns the status word: bit 2 frame active, bit 3 receive queue empty, bit 4 transmit queue full, bits 9:5 receive level, bits 14:10 transmit level. After reset the status reads 0x0008 and the control word reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | Serial clock from the master, idle low |
| spi_csn | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data from the master |
| spi_miso | output | 1 | Serial data to the master |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops the receive queue at address 1) |
| reg_addr | input | 2 | Register address: 0 control, 1 data, 2 status |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data, combinational from address |

## Verification
Write frames are sent with command bytes 0x00 and 0x5A. These share bit 0 but differ elsewhere, so they show that only bit 0 decides the direction. Read frames use 0x01 and 0xA5 and carry nonzero MOSI patterns, so any byte wrongly stored from a read frame would show up in the receive level. The control word is varied through break set, receive disabled, SPI select off and all zero, which separates each enable bit's effect. A seventeen-byte write and a read of an empty transmit queue reach both sticky flags, and an aborted three-bit frame shows that command detection restarts at the next chip select.

// File: rtl/spi_dir_pkg.sv
package spi_dir_pkg;

  localparam int REG_W   = 16;
  localparam int BYTE_W  = 8;

  localparam int CB_EN   = 0;
  localparam int CB_SPI  = 1;
  localparam int CB_BRK  = 7;
  localparam int CB_TXE  = 8;
  localparam int CB_RXE  = 9;

  localparam logic [1:0] RA_CTRL = 2'd0;
  localparam logic [1:0] RA_DATA = 2'd1;
  localparam logic [1:0] RA_STAT = 2'd2;

  // Device services frames only when enabled and in serial mode.
  function automatic logic dev_active(input logic [REG_W-1:0] c);
    return c[CB_EN] & c[CB_SPI];
  endfunction

  // Status word assembly; level fields are five bits wide.
  function automatic logic [REG_W-1:0] pack_status(
    input logic ovr, input logic udr, input logic busy,
    input logic rx_empty, input logic tx_full,
    input logic [4:0] rx_lvl, input logic [4:0] tx_lvl);
    return {1'b0, tx_lvl, rx_lvl, tx_full, rx_empty, busy, udr, ovr};
  endfunction

  // Sticky flag update: set wins, a status write keeps only the bits written as 1.
  function automatic logic sticky_next(input logic cur, input logic set,
                                       input logic clr_wr, input logic keep_bit);
    return set | (cur & ~(clr_wr & ~keep_bit));
  endfunction

endpackage

// File: rtl/spi_dir_sync.sv
module spi_dir_sync #(
  parameter int               W       = 3,
  parameter int               STAGES  = 2,
  parameter logic [W-1:0]     RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[s] <= RST_VAL;
        else if (s == 0) stg[s] <= d;
        else stg[s] <= stg[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/spi_dir_fifo.sv
module spi_dir_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [DW-1:0] din,
  input  logic          pop,
  output logic [DW-1:0] dout,
  output logic          empty,
  output logic          full,
  output logic [CW-1:0] level
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          do_push, do_pop;

  assign empty   = (level == '0);
  assign full    = (level == CW'(DEPTH));
  assign do_push = push & ~full & ~flush;
  assign do_pop  = pop & ~empty & ~flush;
  assign dout    = mem[rp];

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH-1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; level <= '0;
    end else if (flush) begin
      wp <= '0; rp <= '0; level <= '0;
    end else begin
      if (do_push) wp <= ptr_inc(wp);
      if (do_pop)  rp <= ptr_inc(rp);
      case ({do_push, do_pop})
        2'b10:   level <= level + CW'(1);
        2'b01:   level <= level - CW'(1);
        default: level <= level;
      endcase
    end
  end
endmodule

// File: rtl/spi_dir_engine.sv
module spi_dir_engine #(
  parameter int  BW    = 8,
  localparam int CNT_W = $clog2(BW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sclk_s,
  input  logic          mosi_s,
  input  logic          csn_s,
  input  logic          active,
  input  logic          rx_en,
  input  logic          tx_avail,
  input  logic [BW-1:0] tx_head,
  output logic          rx_push,
  output logic [BW-1:0] rx_byte,
  output logic          tx_pop,
  output logic          tx_starve,
  output logic          miso,
  output logic          in_frame,
  output logic          cmd_phase,
  output logic          rd_mode
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BW-1);

  logic             sclk_q;
  logic [CNT_W-1:0] bit_cnt;
  logic [BW-2:0]    sh_in;
  logic [BW-1:0]    sh_out;
  logic             rise, fall, byte_done, slot_start;

  assign in_frame   = ~csn_s & active;
  assign rise       = in_frame & sclk_s & ~sclk_q;
  assign fall       = in_frame & ~sclk_s & sclk_q;
  assign byte_done  = rise & (bit_cnt == LAST);
  assign slot_start = rise & rd_mode & (bit_cnt == '0);
  assign rx_byte    = {sh_in, mosi_s};
  assign rx_push    = byte_done & ~cmd_phase & ~rd_mode & rx_en;
  assign tx_pop     = slot_start & tx_avail;
  assign tx_starve  = slot_start & ~tx_avail;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_q <= 1'b0;
    else        sclk_q <= sclk_s;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt   <= '0;
      sh_in     <= '0;
      sh_out    <= '0;
      cmd_phase <= 1'b1;
      rd_mode   <= 1'b0;
      miso      <= 1'b0;
    end else if (!in_frame) begin
      bit_cnt   <= '0;
      cmd_phase <= 1'b1;
      rd_mode   <= 1'b0;
      miso      <= 1'b0;
    end else begin
      if (rise) begin
        sh_in   <= {sh_in[BW-3:0], mosi_s};
        bit_cnt <= bit_cnt + CNT_W'(1);
        if (slot_start) sh_out <= tx_avail ? tx_head : '0;
        if (byte_done && cmd_phase) begin
          cmd_phase <= 1'b0;
          rd_mode   <= mosi_s;
        end
      end
      if (fall) begin
        if (!rd_mode)            miso <= 1'b0;
        else if (bit_cnt == '0)  miso <= tx_avail & tx_head[BW-1];
        else                     miso <= sh_out[LAST - bit_cnt];
      end
    end
  end
endmodule

// File: rtl/spi_dir_slave.sv
module spi_dir_slave #(
  parameter int  DEPTH = 16,
  localparam int DW    = spi_dir_pkg::BYTE_W,
  localparam int RW    = spi_dir_pkg::REG_W,
  localparam int LW    = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          spi_sclk,
  input  logic          spi_csn,
  input  logic          spi_mosi,
  output logic          spi_miso,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [1:0]    reg_addr,
  input  logic [RW-1:0] reg_wdata,
  output logic [RW-1:0] reg_rdata
);
  import spi_dir_pkg::*;

  logic [RW-1:0] ctrl;
  logic          ovr, udr;
  logic [2:0]    pins_s;
  logic          sclk_s, mosi_s, csn_s;
  logic          active, txe, rxe;

  logic          eng_rx_push, eng_tx_pop, tx_starve;
  logic          in_frame, cmd_phase, rd_mode;
  logic [DW-1:0] eng_rx_byte;

  logic [DW-1:0] rx_head, tx_head;
  logic          rx_empty, rx_full, tx_empty, tx_full;
  logic [LW-1:0] rx_level, tx_level;

  logic          ctrl_wr, data_wr, data_rd, stat_wr;

  spi_dir_sync #(.W(3), .STAGES(2), .RST_VAL(3'b100)) sync_i (
    .clk(clk), .rst_n(rst_n),
    .d({spi_csn, spi_sclk, spi_mosi}), .q(pins_s)
  );
  assign {csn_s, sclk_s, mosi_s} = pins_s;

  assign active  = dev_active(ctrl);
  assign txe     = ctrl[CB_TXE];
  assign rxe     = ctrl[CB_RXE];
  assign ctrl_wr = reg_wr & (reg_addr == RA_CTRL);
  assign data_wr = reg_wr & (reg_addr == RA_DATA);
  assign data_rd = reg_rd & (reg_addr == RA_DATA);
  assign stat_wr = reg_wr & (reg_addr == RA_STAT);

  spi_dir_engine #(.BW(DW)) eng_i (
    .clk(clk), .rst_n(rst_n),
    .sclk_s(sclk_s), .mosi_s(mosi_s), .csn_s(csn_s),
    .active(active), .rx_en(rxe),
    .tx_avail(~tx_empty), .tx_head(tx_head),
    .rx_push(eng_rx_push), .rx_byte(eng_rx_byte),
    .tx_pop(eng_tx_pop), .tx_starve(tx_starve),
    .miso(spi_miso), .in_frame(in_frame),
    .cmd_phase(cmd_phase), .rd_mode(rd_mode)
  );

  spi_dir_fifo #(.DW(DW), .DEPTH(DEPTH)) rxq_i (
    .clk(clk), .rst_n(rst_n), .flush(1'b0),
    .push(eng_rx_push), .din(eng_rx_byte), .pop(data_rd),
    .dout(rx_head), .empty(rx_empty), .full(rx_full), .level(rx_level)
  );

  spi_dir_fifo #(.DW(DW), .DEPTH(DEPTH)) txq_i (
    .clk(clk), .rst_n(rst_n), .flush(~txe),
    .push(data_wr), .din(reg_wdata[DW-1:0]), .pop(eng_tx_pop),
    .dout(tx_head), .empty(tx_empty), .full(tx_full), .level(tx_level)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= '0;
      ovr  <= 1'b0;
      udr  <= 1'b0;
    end else begin
      if (ctrl_wr) ctrl <= reg_wdata;
      ovr <= sticky_next(ovr, eng_rx_push & rx_full, stat_wr, reg_wdata[0]);
      udr <= sticky_next(udr, tx_starve, stat_wr, reg_wdata[1]);
    end
  end

  always_comb begin
    case (reg_addr)
      RA_CTRL: reg_rdata = ctrl;
      RA_DATA: reg_rdata = rx_empty ? '0 : RW'(rx_head);
      RA_STAT: reg_rdata = pack_status(ovr, udr, in_frame, rx_empty, tx_full,
                                       5'(rx_level), 5'(tx_level));
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/spi_dir_slave_chk.sv
module spi_dir_slave_chk (
  input logic clk,
  input logic rst_n,
  input logic active,
  input logic txe,
  input logic in_frame,
  input logic cmd_phase,
  input logic rd_mode,
  input logic miso,
  input logic eng_rx_push,
  input logic eng_tx_pop,
  input logic tx_starve,
  input logic rx_full,
  input logic tx_empty,
  input logic ovr,
  input logic udr,
  input logic stat_wr
);
  a_r1_cmd_not_stored: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_phase |-> !eng_rx_push);

  a_r2_write_miso_low: assert property (@(posedge clk) disable iff (!rst_n)
    (in_frame && !rd_mode) |-> !miso);

  a_r3_read_no_rx: assert property (@(posedge clk) disable iff (!rst_n)
    rd_mode |-> !eng_rx_push);

  a_r3_pop_has_data: assert property (@(posedge clk) disable iff (!rst_n)
    eng_tx_pop |-> !tx_empty);

  a_r4_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> (!eng_rx_push && !eng_tx_pop && !tx_starve));

  a_r6_tx_flushed: assert property (@(posedge clk) disable iff (!rst_n)
    !txe |=> tx_empty);

  a_r9_ovr_set: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_rx_push && rx_full) |=> ovr);

  a_r9_ovr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr && !stat_wr) |=> ovr);

  a_r9_udr_set: assert property (@(posedge clk) disable iff (!rst_n)
    tx_starve |=> udr);
endmodule

bind spi_dir_slave spi_dir_slave_chk chk_i (
  .clk(clk), .rst_n(rst_n), .active(active), .txe(txe),
  .in_frame(in_frame), .cmd_phase(cmd_phase), .rd_mode(rd_mode),
  .miso(spi_miso), .eng_rx_push(eng_rx_push), .eng_tx_pop(eng_tx_pop),
  .tx_starve(tx_starve), .rx_full(rx_full), .tx_empty(tx_empty),
  .ovr(ovr), .udr(udr), .stat_wr(stat_wr)
);

// File: tb/spi_dir_slave_tb.sv
module spi_dir_slave_tb_top;
  localparam int HALF = 8;
  localparam int QD   = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        spi_sclk = 1'b0, spi_csn = 1'b1, spi_mosi = 1'b0;
  logic        spi_miso;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [15:0] reg_wdata = 16'h0;
  logic [15:0] reg_rdata;

  int total = 0;
  int bad   = 0;

  // reference model
  logic [7:0]  m_rx[$];
  logic [7:0]  m_tx[$];
  logic        m_ovr = 1'b0, m_udr = 1'b0;
  logic [15:0] m_ctrl = 16'h0;
  logic [7:0]  payload[$];

  always #2.5 clk = ~clk;

  spi_dir_slave dut_i (
    .clk(clk), .rst_n(rst_n), .spi_sclk(spi_sclk), .spi_csn(spi_csn),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_status();
    logic [15:0] s;
    s = 16'h0;
    s[0] = m_ovr;
    s[1] = m_udr;
    s[3] = (m_rx.size() == 0);
    s[4] = (m_tx.size() == QD);
    s[9:5]   = 5'(m_rx.size());
    s[14:10] = 5'(m_tx.size());
    return s;
  endfunction

  task automatic reg_write(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
    if (a == 2'd0) begin
      m_ctrl = d;
      if (!d[8]) m_tx.delete();
    end else if (a == 2'd1) begin
      if (m_ctrl[8] && m_tx.size() < QD) m_tx.push_back(d[7:0]);
    end else if (a == 2'd2) begin
      m_ovr = m_ovr & d[0];
      m_udr = m_udr & d[1];
    end
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic check_data(input string req);
    logic [15:0] v, e;
    e = (m_rx.size() == 0) ? 16'h0 : {8'h0, m_rx.pop_front()};
    reg_read(2'd1, v);
    check(req, v, e);
  endtask

  task automatic check_status(input string req);
    logic [15:0] v;
    reg_read(2'd2, v);
    check(req, v, exp_status());
  endtask

  task automatic spi_byte(input logic [7:0] o, output logic [7:0] i_b);
    for (int b = 7; b >= 0; b--) begin
      spi_mosi = o[b];
      repeat (HALF) @(negedge clk);
      i_b[b] = spi_miso;
      spi_sclk = 1'b1;
      repeat (HALF) @(negedge clk);
      spi_sclk = 1'b0;
    end
  endtask

  // full frame: command byte then payload; model predicts MISO bytes and queues
  task automatic run_frame(input string req, input logic [7:0] cmd);
    logic [7:0] got, exp_b;
    logic act;
    act = m_ctrl[0] & m_ctrl[1];
    spi_csn = 1'b0;
    repeat (HALF) @(negedge clk);
    spi_byte(cmd, got);
    check({req, " cmd slot miso"}, 16'(got), 16'h0);
    foreach (payload[k]) begin
      exp_b = 8'h0;
      if (act && cmd[0]) begin
        if (m_tx.size() > 0) exp_b = m_tx.pop_front();
        else m_udr = 1'b1;
      end
      spi_byte(payload[k], got);
      check({req, " miso byte"}, 16'(got), 16'(exp_b));
      if (act && !cmd[0] && m_ctrl[9]) begin
        if (m_rx.size() < QD) m_rx.push_back(payload[k]);
        else m_ovr = 1'b1;
      end
    end
    repeat (HALF) @(negedge clk);
    spi_csn = 1'b1;
    repeat (2*HALF) @(negedge clk);
  endtask

  task automatic partial_frame(input int nbits);
    spi_csn = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int b = 0; b < nbits; b++) begin
      spi_mosi = 1'b1;
      repeat (HALF) @(negedge clk);
      spi_sclk = 1'b1;
      repeat (HALF) @(negedge clk);
      spi_sclk = 1'b0;
    end
    repeat (HALF) @(negedge clk);
    spi_csn = 1'b1;
    repeat (2*HALF) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=expired exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    logic [15:0] v;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R10 reset state
    reg_read(2'd0, v);  check("R10 reset ctrl", v, 16'h0);
    reg_read(2'd2, v);  check("R10 reset status", v, 16'h0008);
    check("R10 reset miso", 16'(spi_miso), 16'h0);

    // R1 R2 write frame, command never stored
    reg_write(2'd0, 16'h0303);
    payload = '{8'hDE, 8'hAD, 8'hBE, 8'hEF};
    run_frame("R2 write", 8'h00);
    check_status("R1 four bytes only");
    for (int k = 0; k < 4; k++) check_data("R2 rx order");

    // R1 command 0x5A: bit0=0 still write
    payload = '{8'h3C, 8'hC3};
    run_frame("R1 write cmd5A", 8'h5A);
    check_status("R1 cmd5A level");
    check_data("R1 cmd5A b0");
    check_data("R1 cmd5A b1");

    // R3 read frame, MOSI ignored
    reg_write(2'd1, 16'h0011);
    reg_write(2'd1, 16'h00A2);
    reg_write(2'd1, 16'h0033);
    check_status("R10 tx level");
    payload = '{8'hFF, 8'h55, 8'h0F};
    run_frame("R3 read", 8'h01);
    check_status("R3 rx untouched");

    // R9 underrun on empty tx, cmd 0xA5
    payload = '{8'h12, 8'h34};
    run_frame("R9 underrun", 8'hA5);
    check_status("R9 udr flag");
    reg_write(2'd2, 16'h0000);
    check_status("R9 clear flags");

    // R9 overrun: 17 bytes
    payload.delete();
    for (int k = 0; k < 17; k++) payload.push_back(8'(k * 7 + 1));
    run_frame("R9 overrun", 8'h00);
    check_status("R9 ovr flag");
    reg_write(2'd2, 16'h0002);
    check_status("R9 clear ovr keep");
    for (int k = 0; k < 16; k++) check_data("R9 drain");
    check_data("R10 empty read");

    // R5 break bit ignored
    reg_write(2'd0, 16'h0383);
    payload = '{8'h81};
    run_frame("R5 brk write", 8'h00);
    check_status("R5 brk level");
    check_data("R5 brk data");
    reg_write(2'd1, 16'h0066);
    payload = '{8'h00};
    run_frame("R5 brk read", 8'h01);

    // R6 transmit enable toggle flushes
    reg_write(2'd0, 16'h0303);
    reg_write(2'd1, 16'h0077);
    reg_write(2'd1, 16'h0088);
    reg_write(2'd0, 16'h0203);
    reg_write(2'd1, 16'h0099);
    check_status("R6 held empty");
    reg_write(2'd0, 16'h0303);
    check_status("R6 flushed");
    payload = '{8'h00};
    run_frame("R6 read after flush", 8'h01);
    reg_write(2'd2, 16'h0000);

    // R7 receive disabled
    reg_write(2'd0, 16'h0103);
    payload = '{8'h44, 8'h45};
    run_frame("R7 rx off", 8'h00);
    check_status("R7 no store");

    // R4 device off and SPI select off
    reg_write(2'd0, 16'h0000);
    reg_write(2'd0, 16'h0301);
    reg_write(2'd1, 16'h00AB);
    payload = '{8'h21};
    run_frame("R4 spi off read", 8'h01);
    run_frame("R4 spi off write", 8'h00);
    check_status("R4 queues unchanged");
    reg_write(2'd0, 16'h0000);
    payload = '{8'h22};
    run_frame("R4 zero ctrl", 8'h00);
    check_status("R4 zero ctrl status");

    // R8 aborted frame rearms command detection
    reg_write(2'd0, 16'h0303);
    partial_frame(3);
    payload = '{8'h6E};
    run_frame("R8 after abort", 8'h00);
    check_status("R8 level");
    check_data("R8 data");
    reg_write(2'd1, 16'h00C4);
    payload = '{8'h00};
    run_frame("R8 read then", 8'h01);
    payload = '{8'h5D};
    run_frame("R8 next write", 8'h00);
    check_data("R8 next data");
    check_status("R8 final");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule